// File: doc/BRIEF.md
# Memory-Operand Micro-Op Cracker

This block sits after instruction decode and turns one instruction that may name memory operands into a short run of simple micro-ops. The instruction carries a destination register, an ALU function code and two source operands. Each source is either a plain register, a register-deferred reference whose address is the base register's value, or a displacement reference whose address is the base register plus a signed offset. The cracker sends out one micro-op per accepted output handshake: loads into two reserved temporary registers, followed by one register-register compute micro-op.

A per-instruction mode bit picks between two decompositions. In plain mode each memory operand gets its own load, so only loads reach memory. In load-op mode the last memory operand is folded into the compute micro-op, which reads memory itself, and the run is one micro-op shorter. Both sides use a valid/ready handshake. A new instruction is taken in the same cycle that the final micro-op of the current one is consumed, so back-to-back instructions leave no idle cycle.

Top module: `uop_cracker`

## Requirements
- R1: While and right after synchronous reset, outValid is 0 and inReady is 1.
- R2: An instruction with both sources register-direct (mode code 0; code 3 is also treated as register-direct) yields one ALU micro-op (outOp=1) with outLast=1, srcA/srcB equal to the source registers, base and displacement 0.
- R3: In plain mode (inLoadOp=0) with both sources in memory, the output is LOAD (outOp=0) into temp1, then LOAD into temp2, then ALU with srcA=temp1 and srcB=temp2; temp1 and temp2 are register numbers ARCH_REGS and ARCH_REGS+1 (32 and 33).
- R4: A register-deferred source (code 1) gives outBase equal to its register and outDisp 0; a displacement source (code 2) gives its register and its displacement unchanged.
- R5: In plain mode with exactly one memory source, the output is one LOAD into temp1 followed by ALU with temp1 in that source's slot and the other register in the other slot.
- R6: In load-op mode with both sources in memory, the output is LOAD into temp1 from the first source, then LOADOP (outOp=2) with srcA=temp1, srcB=0, base/displacement of the second source and outMemSlot=0.
- R7: In load-op mode with one memory source, a single LOADOP is emitted; outMemSlot is 1 when the memory value replaces source A and 0 when it replaces source B, and the other source's register sits in its own field while the memory slot's field is 0.
- R8: While outValid is 1 and outReady is 0, every micro-op output holds its value.
- R9: inReady is 0 while a sequence is in progress unless its last micro-op is being consumed in that cycle, when the next instruction is accepted.
- R10: LOAD micro-ops carry srcA=srcB=0 and a temp register as destination, ALU micro-ops carry base and displacement 0, plain mode never emits LOADOP, and outLast is 1 only on the final micro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction offered |
| inReady | output | 1 | Instruction accepted when high with inValid |
| inLoadOp | input | 1 | 1 selects load-op decomposition |
| inFunc | input | 4 | ALU function code, passed through |
| inDst | input | 6 | Destination register |
| inModeA | input | 2 | Source A mode: 0 reg, 1 deferred, 2 displacement, 3 reg |
| inRegA | input | 6 | Source A register or base |
| inDispA | input | 16 | Source A displacement |
| inModeB | input | 2 | Source B mode, same coding |
| inRegB | input | 6 | Source B register or base |
| inDispB | input | 16 | Source B displacement |
| outValid | output | 1 | Micro-op offered |
| outReady | input | 1 | Micro-op consumed when high with outValid |
| outOp | output | 2 | 0 LOAD, 1 ALU, 2 LOADOP |
| outFunc | output | 4 | ALU function code |
| outDst | output | 6 | Destination register |
| outSrcA | output | 6 | Source A register |
| outSrcB | output | 6 | Source B register |
| outBase | output | 6 | Address base register |
| outDisp | output | 16 | Address displacement |
| outMemSlot | output | 1 | LOADOP only: 1 memory replaces A, 0 replaces B |
| outLast | output | 1 | Final micro-op of the instruction |

## Verification
A corrupted step counter shows up at the ports in the very cycle it goes wrong: a repeated or skipped load, a temp register in the wrong slot, or outLast raised early, and with it inReady opening too soon. A stale captured instruction shows as wrong base, displacement or destination on the first micro-op after acceptance. The bench compares every output field and both ready/valid signals against a queue-based model on every clock, including stall cycles where the outputs must not move.

// File: rtl/uop_cracker_pkg.sv
package uop_cracker_pkg;
  parameter int ARCH_REGS = 32;
  parameter int DISP_W = 16;
  parameter int FN_W = 4;
  localparam int REG_W = $clog2(ARCH_REGS + 2);
  localparam int TEMP1 = ARCH_REGS;
  localparam int TEMP2 = ARCH_REGS + 1;
  localparam int STEP_W = 2;

  typedef enum logic [1:0] {
    AM_REG = 2'd0, AM_DEFER = 2'd1, AM_DISP = 2'd2, AM_RSVD = 2'd3
  } addrMode_e;

  typedef enum logic [1:0] {
    UOP_LOAD = 2'd0, UOP_ALU = 2'd1, UOP_LOADOP = 2'd2
  } uopKind_e;

  typedef struct packed {
    logic capture;
    logic [STEP_W-1:0] step;
  } ctlStrobe_t;

  typedef struct packed {
    uopKind_e kind;
    logic [FN_W-1:0] func;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
    logic [REG_W-1:0] base;
    logic [DISP_W-1:0] disp;
    logic memSlot;
    logic last;
  } uop_t;
endpackage

// File: rtl/uop_ctrl.sv
module uop_ctrl
  import uop_cracker_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic outReady,
  input  logic seqLast,
  output logic inReady,
  output logic outValid,
  output ctlStrobe_t ctl
);
  logic busy;
  logic [STEP_W-1:0] step;
  logic fire;

  assign outValid = busy;
  assign fire = busy & outReady;
  assign inReady = !busy || (outReady && seqLast);
  assign ctl.capture = inValid & inReady;
  assign ctl.step = step;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
    end else if (ctl.capture) begin
      busy <= 1'b1;
      step <= '0;
    end else if (fire && seqLast) begin
      busy <= 1'b0;
      step <= '0;
    end else if (fire) begin
      step <= step + 1'b1;
    end
  end

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> step <= 2'd2); // R3
  AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |=> busy && step == '0); // R9
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_cracker_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  ctlStrobe_t ctl,
  input  logic inLoadOp,
  input  logic [FN_W-1:0] inFunc,
  input  logic [REG_W-1:0] inDst,
  input  logic [1:0] inModeA,
  input  logic [REG_W-1:0] inRegA,
  input  logic [DISP_W-1:0] inDispA,
  input  logic [1:0] inModeB,
  input  logic [REG_W-1:0] inRegB,
  input  logic [DISP_W-1:0] inDispB,
  output uop_t uop
);
  localparam logic [REG_W-1:0] T1 = REG_W'(TEMP1);
  localparam logic [REG_W-1:0] T2 = REG_W'(TEMP2);

  logic loadOpQ;
  logic [FN_W-1:0] funcQ;
  logic [REG_W-1:0] dstQ, regAQ, regBQ;
  logic [1:0] modeAQ, modeBQ;
  logic [DISP_W-1:0] dispAQ, dispBQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      loadOpQ <= 1'b0; funcQ <= '0; dstQ <= '0;
      modeAQ <= AM_REG; modeBQ <= AM_REG;
      regAQ <= '0; regBQ <= '0; dispAQ <= '0; dispBQ <= '0;
    end else if (ctl.capture) begin
      loadOpQ <= inLoadOp; funcQ <= inFunc; dstQ <= inDst;
      modeAQ <= inModeA; modeBQ <= inModeB;
      regAQ <= inRegA; regBQ <= inRegB; dispAQ <= inDispA; dispBQ <= inDispB;
    end
  end

  logic memA, memB, useA;
  logic [DISP_W-1:0] effA, effB;
  logic [STEP_W-1:0] nLoads;

  always_comb begin
    memA = (modeAQ == AM_DEFER) || (modeAQ == AM_DISP);
    memB = (modeBQ == AM_DEFER) || (modeBQ == AM_DISP);
    effA = (modeAQ == AM_DISP) ? dispAQ : '0;
    effB = (modeBQ == AM_DISP) ? dispBQ : '0;
    if (loadOpQ) nLoads = {1'b0, memA & memB};
    else         nLoads = {1'b0, memA} + {1'b0, memB};
    useA = (ctl.step == '0) && memA;

    uop = '0;
    uop.func = funcQ;
    if (ctl.step < nLoads) begin
      uop.kind = UOP_LOAD;
      uop.dst  = (ctl.step == '0) ? T1 : T2;
      uop.base = useA ? regAQ : regBQ;
      uop.disp = useA ? effA : effB;
    end else begin
      uop.last = 1'b1;
      uop.dst  = dstQ;
      if (loadOpQ && (memA || memB)) begin
        uop.kind = UOP_LOADOP;
        if (memB) begin
          uop.srcA = memA ? T1 : regAQ;
          uop.base = regBQ;
          uop.disp = effB;
          uop.memSlot = 1'b0;
        end else begin
          uop.srcB = regBQ;
          uop.base = regAQ;
          uop.disp = effA;
          uop.memSlot = 1'b1;
        end
      end else begin
        uop.kind = UOP_ALU;
        uop.srcA = memA ? T1 : regAQ;
        uop.srcB = memB ? (memA ? T2 : T1) : regBQ;
      end
    end
  end

  AST_LOAD_NO_REGREAD: assert property (@(posedge clk) disable iff (rst)
    uop.kind == UOP_LOAD |-> uop.srcA == '0 && uop.srcB == '0 && uop.dst >= T1); // R10
  AST_PLAIN_NO_FOLD: assert property (@(posedge clk) disable iff (rst)
    !loadOpQ |-> uop.kind != UOP_LOADOP); // R10
  AST_LAST_NOT_LOAD: assert property (@(posedge clk) disable iff (rst)
    uop.last |-> uop.kind != UOP_LOAD); // R3
endmodule

// File: rtl/uop_cracker.sv
module uop_cracker
  import uop_cracker_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  output logic inReady,
  input  logic inLoadOp,
  input  logic [FN_W-1:0] inFunc,
  input  logic [REG_W-1:0] inDst,
  input  logic [1:0] inModeA,
  input  logic [REG_W-1:0] inRegA,
  input  logic [DISP_W-1:0] inDispA,
  input  logic [1:0] inModeB,
  input  logic [REG_W-1:0] inRegB,
  input  logic [DISP_W-1:0] inDispB,
  output logic outValid,
  input  logic outReady,
  output logic [1:0] outOp,
  output logic [FN_W-1:0] outFunc,
  output logic [REG_W-1:0] outDst,
  output logic [REG_W-1:0] outSrcA,
  output logic [REG_W-1:0] outSrcB,
  output logic [REG_W-1:0] outBase,
  output logic [DISP_W-1:0] outDisp,
  output logic outMemSlot,
  output logic outLast
);
  ctlStrobe_t ctl;
  uop_t uop;

  uop_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .seqLast(uop.last), .inReady(inReady), .outValid(outValid), .ctl(ctl)
  );

  uop_datapath dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .inLoadOp(inLoadOp), .inFunc(inFunc),
    .inDst(inDst), .inModeA(inModeA), .inRegA(inRegA), .inDispA(inDispA),
    .inModeB(inModeB), .inRegB(inRegB), .inDispB(inDispB), .uop(uop)
  );

  assign outOp      = uop.kind;
  assign outFunc    = uop.func;
  assign outDst     = uop.dst;
  assign outSrcA    = uop.srcA;
  assign outSrcB    = uop.srcB;
  assign outBase    = uop.base;
  assign outDisp    = uop.disp;
  assign outMemSlot = uop.memSlot;
  assign outLast    = uop.last;

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !outValid && inReady); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outOp) && $stable(outDst)
      && $stable(outSrcA) && $stable(outSrcB) && $stable(outBase)
      && $stable(outDisp) && $stable(outLast) && $stable(outMemSlot)); // R8
  AST_NO_MIDSEQ_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    inValid && inReady && outValid |-> outReady && outLast); // R9
endmodule

// File: tb/uop_cracker_tb_top.sv
`timescale 1ns/1ps
module uop_cracker_tb_top;
  import uop_cracker_pkg::*;

  typedef struct packed {
    logic [1:0] op;
    logic [FN_W-1:0] fn;
    logic [REG_W-1:0] dst, sa, sb, base;
    logic [DISP_W-1:0] disp;
    logic slot, last;
  } expUop_t;

  logic clk = 0, rst = 1;
  logic inValid = 0, inLoadOp = 0, outReady = 0;
  logic [FN_W-1:0] inFunc = 0;
  logic [REG_W-1:0] inDst = 0, inRegA = 0, inRegB = 0;
  logic [1:0] inModeA = 0, inModeB = 0;
  logic [DISP_W-1:0] inDispA = 0, inDispB = 0;
  logic inReady, outValid, outMemSlot, outLast;
  logic [1:0] outOp;
  logic [FN_W-1:0] outFunc;
  logic [REG_W-1:0] outDst, outSrcA, outSrcB, outBase;
  logic [DISP_W-1:0] outDisp;

  always #2 clk = ~clk;

  uop_cracker dut_i (.*);

  expUop_t q[$];
  string tagQ[$];
  int compared = 0, mismatched = 0;
  bit done = 0, stallPrev = 0;

  function automatic void pushU(int op, int dst, int sa, int sb, int base,
                                int disp, int slot, string tag);
    expUop_t u;
    u.op = 2'(op); u.fn = inFunc; u.dst = REG_W'(dst); u.sa = REG_W'(sa);
    u.sb = REG_W'(sb); u.base = REG_W'(base); u.disp = DISP_W'(disp);
    u.slot = slot[0]; u.last = 0;
    q.push_back(u); tagQ.push_back(tag);
  endfunction

  // Expand the offered instruction into expected micro-ops from the requirements.
  function automatic void expand();
    bit ma = (inModeA == 1) || (inModeA == 2);
    bit mb = (inModeB == 1) || (inModeB == 2);
    int ea = (inModeA == 2) ? int'(inDispA) : 0;
    int eb = (inModeB == 2) ? int'(inDispB) : 0;
    int t1 = ARCH_REGS, t2 = ARCH_REGS + 1;
    string tag;
    expUop_t u;
    if (!ma && !mb) begin
      tag = "R2";
      pushU(1, inDst, inRegA, inRegB, 0, 0, 0, tag);
    end else if (!inLoadOp) begin
      int sa = inRegA, sb = inRegB;
      tag = (ma && mb) ? "R3/R4/R10" : "R5/R4/R10";
      if (ma) begin pushU(0, t1, 0, 0, inRegA, ea, 0, tag); sa = t1; end
      if (mb) begin
        sb = ma ? t2 : t1;
        pushU(0, sb, 0, 0, inRegB, eb, 0, tag);
      end
      pushU(1, inDst, sa, sb, 0, 0, 0, tag);
    end else if (ma && mb) begin
      tag = "R6/R4";
      pushU(0, t1, 0, 0, inRegA, ea, 0, tag);
      pushU(2, inDst, t1, 0, inRegB, eb, 0, tag);
    end else if (mb) begin
      tag = "R7/R4";
      pushU(2, inDst, inRegA, 0, inRegB, eb, 0, tag);
    end else begin
      tag = "R7/R4";
      pushU(2, inDst, 0, inRegB, inRegA, ea, 1, tag);
    end
    u = q[$]; u.last = 1; q[$] = u;
  endfunction

  task automatic checkCycle();
    bit expValid = q.size() > 0;
    bit expReady = (q.size() == 0) || (q.size() == 1 && outReady);
    compared++;
    if (outValid !== expValid) begin
      mismatched++;
      $display("FAIL R9 outValid act=%0b exp=%0b", outValid, expValid);
    end
    if (inReady !== expReady) begin
      mismatched++;
      $display("FAIL R9 inReady act=%0b exp=%0b", inReady, expReady);
    end
    if (expValid) begin
      expUop_t a;
      a.op = outOp; a.fn = outFunc; a.dst = outDst; a.sa = outSrcA; a.sb = outSrcB;
      a.base = outBase; a.disp = outDisp; a.slot = outMemSlot; a.last = outLast;
      if (a !== q[0]) begin
        mismatched++;
        $display("FAIL %s%s uop act=%h exp=%h", tagQ[0], stallPrev ? "/R8" : "",
                 a, q[0]);
      end
    end
    stallPrev = expValid && !outReady;
    if (expValid && outReady) begin void'(q.pop_front()); void'(tagQ.pop_front()); end
    if (inValid && expReady) expand();
  endtask

  task automatic drive(bit v, bit lop, int ma, int mb, bit rdy);
    inValid = v; inLoadOp = lop; inModeA = 2'(ma); inModeB = 2'(mb);
    outReady = rdy;
    inFunc = 4'($urandom); inDst = REG_W'($urandom_range(0, ARCH_REGS-1));
    inRegA = REG_W'($urandom_range(0, ARCH_REGS-1));
    inRegB = REG_W'($urandom_range(0, ARCH_REGS-1));
    inDispA = 16'($urandom); inDispB = 16'($urandom);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compared++;
    if (outValid !== 0 || inReady !== 1) begin
      mismatched++;
      $display("FAIL R1 reset act v=%0b r=%0b exp v=0 r=1", outValid, inReady);
    end
    rst = 0;
    // Directed: every mode pair in both forms, output always ready.
    for (int lop = 0; lop < 2; lop++)
      for (int ma = 0; ma < 4; ma++)
        for (int mb = 0; mb < 4; mb++) begin
          @(negedge clk);
          drive(1, lop[0], ma, mb, 1);
          #1 checkCycle();
          while (q.size() > 0) begin
            @(negedge clk);
            drive(0, 0, 0, 0, 1);
            #1 checkCycle();
          end
        end
    // Random traffic with back-pressure (R8, R9).
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      drive($urandom_range(0, 3) != 0, 1'($urandom), $urandom_range(0, 3),
            $urandom_range(0, 3), $urandom_range(0, 2) != 0);
      #1 checkCycle();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule